// File: doc/BRIEF.md
# Serial Read Token Chain Slice

This block is the read-side control of one parallel-to-serial FIFO slice that can be chained with other identical slices onto one shared serial line. Each slice takes whole words from its local storage (seen here as a word source with a valid indication and a one-cycle take strobe) and shifts them out one bit per clock. Read ownership travels around a ring of slices as a one-clock token pulse. A slice's token output feeds the next slice's token input, and the last slice wraps back to the first. The slice holding the token shifts out exactly one word. While its last bit is on the line it pulses its token output, so the next slice starts its first bit on the following cycle with no gap.

The slice selects its role during reset. A token input held high marks a stand-alone slice. Such a slice always owns the line, and its token output pin instead carries an almost-empty/almost-full level supplied by the storage. In a chain, the slice whose first-load/direction input is low during reset starts with the token. After reset the same input chooses the bit order of each word as it is loaded. Only the shifting slice enables its serial driver. A stand-alone slice turns its driver on with its first word and keeps the last bit on the line afterwards.

Top module: `ser_token_slice`

## Requirements
- R1: In chain mode, a slice whose `fl_dir` is 0 during reset owns the token after reset, and a slice with `fl_dir` 1 does not. The owner starts shifting on the first clock after reset if a word is available.
- R2: If `tok_in` is 1 during reset, the slice enters stand-alone mode. After reset, `tok_out` then follows `almost_in`.
- R3: In chain mode, `tok_out` never reflects `almost_in`. It carries only token pulses.
- R4: A word is loaded on the clock edge of `word_take`. Its bits appear on `ser_data` one per cycle for WORD_W cycles, starting the cycle after that edge. If `fl_dir` is 0 at the load edge, bit 0 goes first; if it is 1, bit WORD_W-1 goes first.
- R5: In chain mode, `tok_out` is 1 for exactly one cycle per word: the cycle in which the word's last bit is on `ser_data`.
- R6: In chain mode, `ser_oe` is 1 only while the slice holds the token and is shifting. Across a ring, at most one `ser_oe` is 1 in any cycle.
- R7: In stand-alone mode, `ser_oe` is 0 from reset until the first word is loaded and stays 1 afterwards. When no word follows, `ser_data` keeps the last bit shifted.
- R8: A chained slice that receives the token while `word_valid` is 0 keeps the token and leaves `ser_oe` at 0 until a word becomes available. It then shifts that word.
- R9: A token pulse received in a cycle where `word_valid` is 1 loads the next word at the same clock edge, so a full ring produces an uninterrupted stream.
- R10: `word_take` is a single-cycle strobe, asserted only while `word_valid` is 1, once for each word shifted.
- R11: In stand-alone mode, consecutive available words are shifted back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fl_dir | input | 1 | During reset: 0 selects the first token owner. After reset: bit order, 0 for bit 0 first and 1 for the top bit first |
| tok_in | input | 1 | Token pulse from the previous slice; held at 1 for stand-alone use |
| almost_in | input | 1 | Almost-empty/almost-full level from the storage, shown in stand-alone mode |
| word_valid | input | 1 | Storage holds at least one word |
| word_data | input | WORD_W | Oldest stored word |
| word_take | output | 1 | One-cycle pop of the oldest word |
| ser_data | output | 1 | Serial data bit |
| ser_oe | output | 1 | Drive enable for the shared serial line |
| tok_out | output | 1 | Token pulse to the next slice, or the almost level in stand-alone mode |

## Verification
The assertions rely on the following conditions at the inputs:
- `tok_in` is low throughout reset in a chain and steady high in stand-alone use.
- Exactly one slice of a ring sees `fl_dir` low during reset.
- `word_data` stays steady while `word_valid` is high.

The bench drives `fl_dir` from reset for each ring member, so only the first slice is low at reset. It connects the token inputs only to neighbouring token outputs and ties the stand-alone token input to 1. Its word sources change only on the take strobe or while the line is idle. One ring phase deliberately starves a slice after it receives the token, to show that the token is held and that no driver turns on.

// File: rtl/ser_chain_pkg.sv
package ser_chain_pkg;

    typedef enum logic {
        MODE_CASCADE = 1'b0,
        MODE_SINGLE  = 1'b1
    } chain_mode_e;

    typedef struct packed {
        logic busy;
        logic last;
    } shift_stat_t;

    // Ownership after reset: stand-alone always owns, else first-load low owns.
    function automatic logic tok_reset_value(input logic tok_level, input logic first_load);
        return tok_level | ~first_load;
    endfunction

endpackage

// File: rtl/ser_tok_ctrl.sv
module ser_tok_ctrl
    import ser_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fl_dir,
    input  logic        tok_in,
    input  logic        word_done,
    output chain_mode_e mode,
    output logic        has_tok,
    output logic        tok_rx
);

    // Token pulses only count in a chain.
    assign tok_rx = tok_in && (mode == MODE_CASCADE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= tok_in ? MODE_SINGLE : MODE_CASCADE;
            has_tok <= tok_reset_value(tok_in, fl_dir);
        end else if (mode == MODE_SINGLE) begin
            has_tok <= 1'b1;
        end else if (tok_rx) begin
            has_tok <= 1'b1;
        end else if (word_done) begin
            has_tok <= 1'b0;
        end
    end

endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter
    import ser_chain_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              msb_first,
    input  logic [WORD_W-1:0] word,
    output shift_stat_t       stat,
    output logic              bit_out
);

    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

    logic [WORD_W-1:0] ordered;
    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic              busy;

    // Place the first bit to leave at position 0.
    for (genvar b = 0; b < WORD_W; b++) begin : g_order
        assign ordered[b] = msb_first ? word[WORD_W-1-b] : word[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            shreg <= ordered;
        end else if (busy) begin
            if (cnt == LAST_IDX) begin
                busy <= 1'b0;          // last bit stays on the line
            end else begin
                cnt   <= cnt + 1'b1;
                shreg <= shreg >> 1;
            end
        end
    end

    assign stat.busy = busy;
    assign stat.last = busy && (cnt == LAST_IDX);
    assign bit_out   = shreg[0];

endmodule

// File: rtl/ser_token_slice.sv
module ser_token_slice
    import ser_chain_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_dir,
    input  logic              tok_in,
    input  logic              almost_in,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_take,
    output logic              ser_data,
    output logic              ser_oe,
    output logic              tok_out
);

    chain_mode_e mode;
    shift_stat_t stat;
    logic        has_tok;
    logic        tok_rx;
    logic        single;
    logic        start;
    logic        oe_hold;
    logic        tok_pulse;

    assign single = (mode == MODE_SINGLE);

    // Load when owning (or just handed the token) and idle; stand-alone may
    // also reload on the last bit for a gapless stream.
    assign start = !rst && word_valid &&
                   ((!stat.busy && (has_tok || tok_rx)) || (stat.last && single));

    ser_tok_ctrl u_tok (
        .clk       (clk),
        .rst       (rst),
        .fl_dir    (fl_dir),
        .tok_in    (tok_in),
        .word_done (stat.last),
        .mode      (mode),
        .has_tok   (has_tok),
        .tok_rx    (tok_rx)
    );

    ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .msb_first (fl_dir),
        .word      (word_data),
        .stat      (stat),
        .bit_out   (ser_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_hold <= 1'b0;
        end else if (start) begin
            oe_hold <= 1'b1;
        end
    end

    assign tok_pulse = !rst && !single && stat.last;
    assign tok_out   = (!rst && single) ? almost_in : tok_pulse;
    assign ser_oe    = single ? oe_hold : stat.busy;
    assign word_take = start;

endmodule

// File: rtl/ser_token_slice_chk.sv
module ser_token_slice_chk (
    input logic clk,
    input logic rst,
    input logic single,
    input logic has_tok,
    input logic busy,
    input logic start,
    input logic word_valid,
    input logic word_take,
    input logic ser_oe,
    input logic ser_data,
    input logic tok_out
);

    p_take_valid_r10: assert property (@(posedge clk) disable iff (rst)
        word_take |-> word_valid);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        (!single && tok_out) |=> !tok_out);

    p_pulse_on_line_r5: assert property (@(posedge clk) disable iff (rst)
        (!single && tok_out) |-> ser_oe);

    p_oe_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (!single && ser_oe) |-> has_tok);

    p_oe_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (single && ser_oe) |=> ser_oe);

    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (single && !busy && !start) |=> $stable(ser_data));

    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!single && !busy && !word_valid) |=> !ser_oe);

endmodule

bind ser_token_slice ser_token_slice_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .single     (single),
    .has_tok    (has_tok),
    .busy       (stat.busy),
    .start      (start),
    .word_valid (word_valid),
    .word_take  (word_take),
    .ser_oe     (ser_oe),
    .ser_data   (ser_data),
    .tok_out    (tok_out)
);

// File: tb/ser_token_slice_tb.sv
module ser_token_slice_tb;

    localparam int W = 16;
    localparam logic [W-1:0] VEC [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                        16'hFFFF, 16'h1234, 16'h0F0E};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b1;
    logic dir_r = 1'b0;
    logic almost_ring = 1'b0;
    logic almost_s = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // ring of three slices
    logic [2:0] oe, sd, take, wv, tok_ring, fl_ring;
    logic [W-1:0] wd [3];
    logic [W-1:0] mem [3][8];
    int n [3];
    int idx [3];

    for (genvar i = 0; i < 3; i++) begin : g_ring
        localparam int PREV = (i + 2) % 3;
        assign wv[i] = (idx[i] < n[i]);
        assign wd[i] = mem[i][idx[i][2:0]];
        assign fl_ring[i] = rst ? (i != 0) : dir_r;
        ser_token_slice #(.WORD_W(W)) u_dut (
            .clk(clk), .rst(rst), .fl_dir(fl_ring[i]), .tok_in(tok_ring[PREV]),
            .almost_in(almost_ring), .word_valid(wv[i]), .word_data(wd[i]),
            .word_take(take[i]), .ser_data(sd[i]), .ser_oe(oe[i]), .tok_out(tok_ring[i]));
    end

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (clr) idx[i] <= 0;
            else if (take[i]) idx[i] <= idx[i] + 1;
        end
    end

    // stand-alone slice
    logic s_take, s_sd, s_oe, s_tok;
    logic [W-1:0] s_mem [4];
    int s_n = 0;
    int s_idx;
    always @(posedge clk) begin
        if (clr) s_idx <= 0;
        else if (s_take) s_idx <= s_idx + 1;
    end

    ser_token_slice #(.WORD_W(W)) u_dut_single (
        .clk(clk), .rst(rst), .fl_dir(dir_r), .tok_in(1'b1), .almost_in(almost_s),
        .word_valid(s_idx < s_n), .word_data(s_mem[s_idx[1:0]]), .word_take(s_take),
        .ser_data(s_sd), .ser_oe(s_oe), .tok_out(s_tok));

    // stream collector for the ring
    logic cap [256];
    int cap_cnt, multi, first_c, last_c, cyc;
    int pulses [3];
    always @(negedge clk) begin
        if (rst) begin
            cap_cnt = 0; multi = 0; first_c = -1; last_c = -1; cyc = 0;
            for (int i = 0; i < 3; i++) pulses[i] = 0;
        end else begin
            cyc++;
            if ($countones(oe) > 1) multi++;
            if ($countones(oe) == 1) begin
                if (first_c < 0) first_c = cyc;
                last_c = cyc;
                if (cap_cnt < 256) cap[cap_cnt] = oe[0] ? sd[0] : (oe[1] ? sd[1] : sd[2]);
                cap_cnt++;
            end
            for (int i = 0; i < 3; i++) pulses[i] += int'(tok_ring[i]);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] word_at(input int k, input logic d);
        logic [W-1:0] w;
        for (int j = 0; j < W; j++) begin
            if (d) w[W-1-j] = cap[k*W + j];
            else   w[j]     = cap[k*W + j];
        end
        return w;
    endfunction

    task automatic ring_reset(input logic d);
        @(negedge clk);
        rst = 1'b1; clr = 1'b1; dir_r = d;
        for (int i = 0; i < 3; i++) n[i] = 0;
        s_n = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ring_full(input logic d);
        ring_reset(d);
        for (int k = 0; k < 6; k++) mem[k % 3][k / 3] = VEC[k];
        for (int i = 0; i < 3; i++) n[i] = 2;
        almost_ring = 1'b1;
        rst = 1'b0; clr = 1'b0;
        @(negedge clk);
        chk(oe == 3'b001, "R1 first owner drives", 32'(oe), 32'h1);
        chk(tok_ring[1] == 1'b0, "R3 almost hidden in chain", 32'(tok_ring[1]), 32'h0);
        repeat (6 * W + 10) @(negedge clk);
        for (int k = 0; k < 6; k++)
            chk(word_at(k, d) == VEC[k], d ? "R4 msb-first word order" : "R4 lsb-first word order",
                32'(word_at(k, d)), 32'(VEC[k]));
        chk(multi == 0, "R6 one driver", 32'(multi), 32'h0);
        chk(last_c - first_c + 1 == 6 * W && cap_cnt == 6 * W, "R9 gapless ring",
            32'(last_c - first_c + 1), 32'(6 * W));
        for (int i = 0; i < 3; i++) begin
            chk(pulses[i] == 2, "R5 one pulse per word", 32'(pulses[i]), 32'h2);
            chk(idx[i] == 2, "R10 one take per word", 32'(idx[i]), 32'h2);
        end
        almost_ring = 1'b0;
    endtask

    initial begin
        ring_full(1'b0);
        ring_full(1'b1);

        // starved receiver keeps the token
        ring_reset(1'b0);
        mem[0][0] = VEC[0]; mem[2][0] = VEC[2];
        n[0] = 1; n[2] = 1;
        rst = 1'b0; clr = 1'b0;
        repeat (40) @(negedge clk);
        chk(oe == 3'b000 && cap_cnt == W, "R8 no driver while empty", 32'(oe), 32'h0);
        mem[1][0] = VEC[1]; n[1] = 1;
        repeat (2 * W + 8) @(negedge clk);
        chk(cap_cnt == 3 * W, "R8 bit count", 32'(cap_cnt), 32'(3 * W));
        for (int k = 0; k < 3; k++)
            chk(word_at(k, 1'b0) == VEC[k], "R8 order after late word", 32'(word_at(k, 1'b0)), 32'(VEC[k]));
        chk(multi == 0, "R6 one driver after stall", 32'(multi), 32'h0);

        // stand-alone slice
        ring_reset(1'b0);
        s_mem[0] = VEC[0]; s_mem[1] = VEC[5];
        chk(s_oe == 1'b0, "R7 released in reset", 32'(s_oe), 32'h0);
        rst = 1'b0; clr = 1'b0;
        @(negedge clk);
        chk(s_oe == 1'b0, "R7 no drive before first word", 32'(s_oe), 32'h0);
        almost_s = 1'b1; #1;
        chk(s_tok == 1'b1, "R2 almost shown high", 32'(s_tok), 32'h1);
        almost_s = 1'b0; #1;
        chk(s_tok == 1'b0, "R2 almost shown low", 32'(s_tok), 32'h0);
        @(negedge clk);
        s_n = 2;
        @(negedge clk);
        begin
            logic [2*W-1:0] got;
            int oe_lo;
            oe_lo = 0;
            for (int j = 0; j < 2 * W; j++) begin
                got[j] = s_sd;
                if (!s_oe) oe_lo++;
                @(negedge clk);
            end
            chk(oe_lo == 0, "R11 no idle between words", 32'(oe_lo), 32'h0);
            chk(got[W-1:0] == VEC[0], "R11 first word", 32'(got[W-1:0]), 32'(VEC[0]));
            chk(got[2*W-1:W] == VEC[5], "R11 second word", 32'(got[2*W-1:W]), 32'(VEC[5]));
        end
        repeat (5) @(negedge clk);
        chk(s_oe == 1'b1, "R7 driver stays on", 32'(s_oe), 32'h1);
        chk(s_sd == VEC[5][W-1], "R7 last bit held", 32'(s_sd), 32'(VEC[5][W-1]));
        chk(s_idx == 2, "R10 stand-alone takes", 32'(s_idx), 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule